// File: doc/BRIEF.md
# Ternary Match Lookup Engine

This block is a small ternary content-addressable table. Every entry holds a data word and a per-bit care mask, so each stored bit matches a key bit of 0, of 1, or of either value. A lookup presents a key together with the number of a global mask register. That register hides further key bits for this lookup only. All entries are compared in parallel, and the lowest-numbered matching entry is reported.

A lookup runs through a fixed two-stage pipeline, and a new one may start on every cycle. Each result carries a completion pulse, a hit flag and a multiple-hit flag alongside the winning index. The index is also stored in one of several result registers, chosen by a field of the request. A maintenance port writes and reads entries, writes the global mask registers and reads back the result registers. Each read answers one cycle after it is issued.

Top module: `tcam_lookup`

## Requirements
- R1: Entry bit b matches when its mask bit is 1, or when the key bit equals the stored data bit. An entry matches only when every bit matches and the entry has been written since reset.
- R2: The global mask register numbered by `gmask_sel_i` at request time hides every key bit where it holds a 1, in addition to the per-entry mask. Global masks reset to all zeros.
- R3: Among the matching entries, `index_o` reports the one with the lowest index.
- R4: `hit_o` is 1 when at least one entry matches and 0 otherwise. `index_o` is 0 on a miss.
- R5: `done_o` pulses high for one cycle exactly two clock edges after each cycle in which `req_i` is sampled high, for hits and misses alike. While `done_o` is low, `hit_o`, `multi_o` and `index_o` are 0.
- R6: `multi_o` is 1 together with `done_o` when two or more entries match.
- R7: On completion, the reported index (0 on a miss) is written to the result register numbered by the `result_sel_i` value captured with the request. Op 2'b11 reads result register `mnt_addr_i[1:0]`, returning the index zero-extended in `rd_data_o`.
- R8: Maintenance ops on `mnt_op_i` are 2'b00 (read entry `mnt_addr_i`), 2'b01 (write entry: data, mask and valid), 2'b10 (write global mask) and 2'b11 (read result). A read raises `rd_valid_o` on the next cycle with `rd_data_o`/`rd_mask_o`. Unwritten entries read as zero.
- R9: Op 2'b10 writes `mnt_data_i` into the global mask register numbered by `mnt_gsel_i`. `mnt_gsel_i` has no effect on read ops.
- R10: After reset, all outputs are 0, no entry is valid and all result registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request strobe |
| key_i | input | KEY_W | Lookup key |
| gmask_sel_i | input | $clog2(N_GMASK) | Global mask register used by this lookup |
| result_sel_i | input | $clog2(N_RESULT) | Result register that receives the index |
| done_o | output | 1 | Lookup complete |
| hit_o | output | 1 | At least one entry matched |
| multi_o | output | 1 | More than one entry matched |
| index_o | output | $clog2(N_ENTRIES) | Lowest matching entry index |
| mnt_valid_i | input | 1 | Maintenance op valid |
| mnt_op_i | input | 2 | Maintenance op code |
| mnt_addr_i | input | $clog2(N_ENTRIES) | Entry address or result register number |
| mnt_gsel_i | input | $clog2(N_GMASK) | Global mask register for op 2'b10 |
| mnt_data_i | input | KEY_W | Write data |
| mnt_mask_i | input | KEY_W | Write mask (1 = don't care) |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | KEY_W | Read data |
| rd_mask_o | output | KEY_W | Read mask |

## Verification
The assertions assume a power-of-two entry count, so every `mnt_addr_i` value names a real entry. They also assume that result reads use only select values below `N_RESULT`, and that reset is applied before the first request. The stimulus drives all inputs on the falling edge and draws addresses and selects only from legal ranges. Requests and maintenance ops come back to back and overlap freely, so writes that land while a lookup is in flight are exercised. Random keys are mostly copies of stored entries with at most one flipped bit, and masks are sparse. This keeps hits, misses and multiple hits all frequent.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    OP_RD_ENTRY  = 2'b00,
    OP_WR_ENTRY  = 2'b01,
    OP_WR_GMASK  = 2'b10,
    OP_RD_RESULT = 2'b11
  } mnt_op_e;
endpackage

// File: rtl/tcam_entry_array.sv
module tcam_entry_array #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned KEY_W     = 72,
  localparam int unsigned AW       = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [KEY_W-1:0]     wr_data_i,
  input  logic [KEY_W-1:0]     wr_mask_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [KEY_W-1:0]     rd_data_o,
  output logic [KEY_W-1:0]     rd_mask_o,
  input  logic [KEY_W-1:0]     key_i,
  input  logic [KEY_W-1:0]     gmask_i,
  output logic [N_ENTRIES-1:0] match_o
);
  logic [KEY_W-1:0]     data_q [N_ENTRIES];
  logic [KEY_W-1:0]     mask_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < int'(N_ENTRIES); i++) begin
        data_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      data_q[wr_addr_i] <= wr_data_i;
      mask_q[wr_addr_i] <= wr_mask_i;
      vld_q[wr_addr_i]  <= 1'b1;
    end
  end

  assign rd_data_o = data_q[rd_addr_i];
  assign rd_mask_o = mask_q[rd_addr_i];

  // one comparator per entry; a 1 in either mask turns the bit into don't-care
  for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_cmp
    logic [KEY_W-1:0] diff;
    assign diff       = (key_i ^ data_q[g]) & ~mask_q[g] & ~gmask_i;
    assign match_o[g] = vld_q[g] & ~|diff;
  end
endmodule

// File: rtl/tcam_gmask_bank.sv
module tcam_gmask_bank #(
  parameter int unsigned KEY_W   = 72,
  parameter int unsigned N_GMASK = 4,
  localparam int unsigned GSW    = $clog2(N_GMASK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [GSW-1:0]   wr_sel_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic [GSW-1:0]   rd_sel_i,
  output logic [KEY_W-1:0] gmask_o
);
  logic [KEY_W-1:0] gm_q [N_GMASK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_GMASK); i++) gm_q[i] <= '0;
    end else if (wr_en_i) begin
      gm_q[wr_sel_i] <= wr_data_i;
    end
  end

  assign gmask_o = gm_q[rd_sel_i];
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned AW       = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] match_i,
  output logic                 hit_o,
  output logic                 multi_o,
  output logic [AW-1:0]        idx_o
);
  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    hit_o   = 1'b0;
    multi_o = 1'b0;
    idx_o   = '0;
    for (int i = int'(N_ENTRIES) - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        if (hit_o) multi_o = 1'b1;
        hit_o = 1'b1;
        idx_o = AW'(i);
      end
    end
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned KEY_W     = 72,
  parameter int unsigned N_GMASK   = 4,
  parameter int unsigned N_RESULT  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [KEY_W-1:0]             key_i,
  input  logic [$clog2(N_GMASK)-1:0]   gmask_sel_i,
  input  logic [$clog2(N_RESULT)-1:0]  result_sel_i,
  output logic                         done_o,
  output logic                         hit_o,
  output logic                         multi_o,
  output logic [$clog2(N_ENTRIES)-1:0] index_o,
  input  logic                         mnt_valid_i,
  input  logic [1:0]                   mnt_op_i,
  input  logic [$clog2(N_ENTRIES)-1:0] mnt_addr_i,
  input  logic [$clog2(N_GMASK)-1:0]   mnt_gsel_i,
  input  logic [KEY_W-1:0]             mnt_data_i,
  input  logic [KEY_W-1:0]             mnt_mask_i,
  output logic                         rd_valid_o,
  output logic [KEY_W-1:0]             rd_data_o,
  output logic [KEY_W-1:0]             rd_mask_o
);
  localparam int unsigned AW  = $clog2(N_ENTRIES);
  localparam int unsigned GSW = $clog2(N_GMASK);
  localparam int unsigned RSW = $clog2(N_RESULT);

  mnt_op_e op;
  assign op = mnt_op_e'(mnt_op_i);

  logic wr_entry, wr_gmask, rd_any;
  assign wr_entry = mnt_valid_i && (op == OP_WR_ENTRY);
  assign wr_gmask = mnt_valid_i && (op == OP_WR_GMASK);
  assign rd_any   = mnt_valid_i && (op == OP_RD_ENTRY || op == OP_RD_RESULT);

  // stage 1: capture key, selected global mask and result slot
  logic [KEY_W-1:0] gmask_sel_val;
  logic             s1_vld_q;
  logic [KEY_W-1:0] s1_key_q, s1_gmask_q;
  logic [RSW-1:0]   s1_rsel_q;

  tcam_gmask_bank #(.KEY_W(KEY_W), .N_GMASK(N_GMASK)) i_gmask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_gmask),
    .wr_sel_i  (mnt_gsel_i),
    .wr_data_i (mnt_data_i),
    .rd_sel_i  (gmask_sel_i),
    .gmask_o   (gmask_sel_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q   <= 1'b0;
      s1_key_q   <= '0;
      s1_gmask_q <= '0;
      s1_rsel_q  <= '0;
    end else begin
      s1_vld_q <= req_i;
      if (req_i) begin
        s1_key_q   <= key_i;
        s1_gmask_q <= gmask_sel_val;
        s1_rsel_q  <= result_sel_i;
      end
    end
  end

  // compare array and priority encode
  logic [N_ENTRIES-1:0] match_vec;
  logic [KEY_W-1:0]     arr_rd_data, arr_rd_mask;
  logic                 hit_c, multi_c;
  logic [AW-1:0]        idx_c;

  tcam_entry_array #(.N_ENTRIES(N_ENTRIES), .KEY_W(KEY_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_entry),
    .wr_addr_i (mnt_addr_i),
    .wr_data_i (mnt_data_i),
    .wr_mask_i (mnt_mask_i),
    .rd_addr_i (mnt_addr_i),
    .rd_data_o (arr_rd_data),
    .rd_mask_o (arr_rd_mask),
    .key_i     (s1_key_q),
    .gmask_i   (s1_gmask_q),
    .match_o   (match_vec)
  );

  tcam_prio_enc #(.N_ENTRIES(N_ENTRIES)) i_prio (
    .match_i (match_vec),
    .hit_o   (hit_c),
    .multi_o (multi_c),
    .idx_o   (idx_c)
  );

  // stage 2: result outputs and result registers
  logic          done_q, hit_q, multi_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] res_q [N_RESULT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      idx_q   <= '0;
      for (int i = 0; i < int'(N_RESULT); i++) res_q[i] <= '0;
    end else begin
      done_q  <= s1_vld_q;
      hit_q   <= s1_vld_q & hit_c;
      multi_q <= s1_vld_q & multi_c;
      idx_q   <= s1_vld_q ? idx_c : '0;
      if (s1_vld_q) res_q[s1_rsel_q] <= idx_c;
    end
  end

  assign done_o  = done_q;
  assign hit_o   = hit_q;
  assign multi_o = multi_q;
  assign index_o = idx_q;

  // maintenance read path
  logic             rd_vld_q;
  logic [KEY_W-1:0] rd_data_d, rd_mask_d, rd_data_q, rd_mask_q;

  always_comb begin
    rd_data_d = '0;
    rd_mask_d = '0;
    if (mnt_valid_i) begin
      unique case (op)
        OP_RD_ENTRY: begin
          rd_data_d = arr_rd_data;
          rd_mask_d = arr_rd_mask;
        end
        OP_RD_RESULT: rd_data_d[AW-1:0] = res_q[mnt_addr_i[RSW-1:0]];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
      rd_mask_q <= '0;
    end else begin
      rd_vld_q  <= rd_any;
      rd_data_q <= rd_data_d;
      rd_mask_q <= rd_mask_d;
    end
  end

  assign rd_valid_o = rd_vld_q;
  assign rd_data_o  = rd_data_q;
  assign rd_mask_o  = rd_mask_q;

  // assertions
  logic [N_ENTRIES-1:0] below_idx;
  assign below_idx = ~({N_ENTRIES{1'b1}} << idx_c);

  p_prio_lowest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |-> (match_vec[idx_c] && ((match_vec & below_idx) == '0)));

  p_miss_idx_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (index_o == '0));

  p_done_follows_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ##2 done_o);

  p_done_has_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_i, 2));

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!hit_o && !multi_o && index_o == '0));

  p_multi_needs_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  p_read_answers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any |=> rd_valid_o);

  p_no_spurious_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_any |=> !rd_valid_o);
endmodule

// File: tb/test_tcam_lookup.sv
module test_tcam_lookup;
  localparam int N  = 64;
  localparam int W  = 72;
  localparam int AW = 6;
  localparam int GW = 2;
  localparam int RW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [W-1:0]  key_i = '0;
  logic [GW-1:0] gmask_sel_i = '0;
  logic [RW-1:0] result_sel_i = '0;
  logic          done_o, hit_o, multi_o;
  logic [AW-1:0] index_o;
  logic          mnt_valid_i = 1'b0;
  logic [1:0]    mnt_op_i = '0;
  logic [AW-1:0] mnt_addr_i = '0;
  logic [GW-1:0] mnt_gsel_i = '0;
  logic [W-1:0]  mnt_data_i = '0;
  logic [W-1:0]  mnt_mask_i = '0;
  logic          rd_valid_o;
  logic [W-1:0]  rd_data_o, rd_mask_o;

  always #4 clk_i = ~clk_i;

  tcam_lookup i_tcam_lookup (
    .clk_i, .rst_ni, .req_i, .key_i, .gmask_sel_i, .result_sel_i,
    .done_o, .hit_o, .multi_o, .index_o,
    .mnt_valid_i, .mnt_op_i, .mnt_addr_i, .mnt_gsel_i, .mnt_data_i, .mnt_mask_i,
    .rd_valid_o, .rd_data_o, .rd_mask_o
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [W-1:0]  m_data [N];
  logic [W-1:0]  m_mask [N];
  bit            m_vld  [N];
  logic [W-1:0]  m_gm   [4];
  logic [AW-1:0] m_res  [4];
  bit            p_v;
  logic [W-1:0]  p_key, p_gm;
  logic [RW-1:0] p_rs;
  bit            e_done, e_hit, e_multi, e_rdv;
  logic [AW-1:0] e_idx;
  logic [W-1:0]  e_rdd, e_rdm;
  string         e_rtag;

  always @(posedge clk_i) begin
    bit            n_rdv, n_v;
    logic [W-1:0]  n_rdd, n_rdm, n_key, n_gm;
    logic [RW-1:0] n_rs;
    string         n_tag;
    int            cnt;
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin m_data[i] = '0; m_mask[i] = '0; m_vld[i] = 0; end
      for (int i = 0; i < 4; i++) begin m_gm[i] = '0; m_res[i] = '0; end
      p_v = 0; p_key = '0; p_gm = '0; p_rs = '0;
      e_done = 0; e_hit = 0; e_multi = 0; e_idx = '0;
      e_rdv = 0; e_rdd = '0; e_rdm = '0; e_rtag = "R10";
    end else begin
      n_rdv = 0; n_rdd = '0; n_rdm = '0; n_tag = "R8";
      if (mnt_valid_i && mnt_op_i == 2'b00) begin
        n_rdv = 1; n_rdd = m_data[mnt_addr_i]; n_rdm = m_mask[mnt_addr_i];
      end else if (mnt_valid_i && mnt_op_i == 2'b11) begin
        n_rdv = 1; n_rdd = W'(m_res[mnt_addr_i[1:0]]); n_tag = "R7";
      end
      n_v = req_i; n_key = key_i; n_gm = m_gm[gmask_sel_i]; n_rs = result_sel_i;
      e_done = p_v; e_hit = 0; e_multi = 0; e_idx = '0;
      if (p_v) begin
        cnt = 0;
        for (int i = 0; i < N; i++)
          if (m_vld[i] && (((p_key ^ m_data[i]) & ~m_mask[i] & ~p_gm) == '0)) begin
            if (cnt == 0) e_idx = AW'(i);
            cnt++;
          end
        e_hit = cnt > 0;
        e_multi = cnt > 1;
        m_res[p_rs] = e_idx;
      end
      e_rdv = n_rdv; e_rdd = n_rdd; e_rdm = n_rdm; e_rtag = n_tag;
      if (mnt_valid_i && mnt_op_i == 2'b01) begin
        m_data[mnt_addr_i] = mnt_data_i; m_mask[mnt_addr_i] = mnt_mask_i; m_vld[mnt_addr_i] = 1;
      end
      if (mnt_valid_i && mnt_op_i == 2'b10) m_gm[mnt_gsel_i] = mnt_data_i;
      p_v = n_v; p_key = n_key; p_gm = n_gm; p_rs = n_rs;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (cmp_on) begin
      chk(done_o == e_done, "R5 done_o", W'(done_o), W'(e_done));
      chk(hit_o == e_hit, "R4 hit_o", W'(hit_o), W'(e_hit));
      chk(multi_o == e_multi, "R6 multi_o", W'(multi_o), W'(e_multi));
      chk(index_o == e_idx, "R3 index_o", W'(index_o), W'(e_idx));
      chk(rd_valid_o == e_rdv, "R8 rd_valid_o", W'(rd_valid_o), W'(e_rdv));
      chk(rd_data_o == e_rdd, {e_rtag, " rd_data_o"}, rd_data_o, e_rdd);
      chk(rd_mask_o == e_rdm, {e_rtag, " rd_mask_o"}, rd_mask_o, e_rdm);
    end
  end

  task automatic wr_entry(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [W-1:0] m);
    @(negedge clk_i);
    mnt_valid_i = 1; mnt_op_i = 2'b01; mnt_addr_i = a; mnt_data_i = d; mnt_mask_i = m;
    @(negedge clk_i);
    mnt_valid_i = 0;
  endtask

  task automatic wr_gm(input logic [GW-1:0] s, input logic [W-1:0] d);
    @(negedge clk_i);
    mnt_valid_i = 1; mnt_op_i = 2'b10; mnt_gsel_i = s; mnt_data_i = d;
    @(negedge clk_i);
    mnt_valid_i = 0;
  endtask

  task automatic rd_chk(input logic [1:0] op, input logic [AW-1:0] a, input logic [GW-1:0] gs,
                        input logic [W-1:0] ed, input logic [W-1:0] em, input string tag);
    @(negedge clk_i);
    mnt_valid_i = 1; mnt_op_i = op; mnt_addr_i = a; mnt_gsel_i = gs;
    @(negedge clk_i);
    mnt_valid_i = 0;
    chk(rd_valid_o == 1'b1, {tag, " read valid"}, W'(rd_valid_o), W'(1));
    chk(rd_data_o == ed, {tag, " read data"}, rd_data_o, ed);
    chk(rd_mask_o == em, {tag, " read mask"}, rd_mask_o, em);
  endtask

  task automatic look_chk(input logic [W-1:0] k, input logic [GW-1:0] gs, input logic [RW-1:0] rs,
                          input bit eh, input logic [AW-1:0] ei, input bit em, input string tag);
    @(negedge clk_i);
    req_i = 1; key_i = k; gmask_sel_i = gs; result_sel_i = rs;
    @(negedge clk_i);
    req_i = 0;
    chk(done_o == 1'b0, {tag, " done not early"}, W'(done_o), W'(0));
    @(negedge clk_i);
    chk(done_o == 1'b1, {tag, " done"}, W'(done_o), W'(1));
    chk(hit_o == eh, {tag, " hit"}, W'(hit_o), W'(eh));
    chk(index_o == ei, {tag, " index"}, W'(index_o), W'(ei));
    chk(multi_o == em, {tag, " multi"}, W'(multi_o), W'(em));
  endtask

  function automatic logic [W-1:0] rnd_w();
    return W'({$urandom(), $urandom(), $urandom()});
  endfunction

  localparam logic [W-1:0] KA = 72'h0A_1122_3344_5566_7788;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cmp_on = 1;
    @(negedge clk_i);
    // R10: idle outputs and empty table after reset
    chk(done_o == 0 && hit_o == 0 && index_o == 0, "R10 idle outputs", W'({done_o, hit_o, index_o}), '0);
    rd_chk(2'b11, 6'd2, 2'd0, '0, '0, "R10 result reg");
    look_chk('0, 2'd0, 2'd0, 0, 6'd0, 0, "R10 R8 empty table miss");
    // R8: writes and reads
    wr_entry(6'd3, KA, '0);
    wr_entry(6'd7, KA, 72'hFF);
    rd_chk(2'b00, 6'd3, 2'd0, KA, '0, "R8 entry 3");
    rd_chk(2'b00, 6'd5, 2'd0, '0, '0, "R8 unwritten entry");
    // R3 R6: both match, lowest wins
    look_chk(KA, 2'd0, 2'd1, 1, 6'd3, 1, "R3 R6 two hits");
    // R1: masked bit lets only entry 7 match
    look_chk(KA ^ 72'h01, 2'd0, 2'd2, 1, 6'd7, 0, "R1 per-entry mask");
    // R4: unmasked mismatch misses
    look_chk(KA ^ 72'h100, 2'd0, 2'd0, 0, 6'd0, 0, "R4 miss");
    // R2: global mask register 2 hides bit 8
    wr_gm(2'd2, 72'h100);
    look_chk(KA ^ 72'h100, 2'd2, 2'd3, 1, 6'd3, 1, "R2 global mask hides bit");
    look_chk(KA ^ 72'h100, 2'd0, 2'd0, 0, 6'd0, 0, "R2 other global mask");
    // R7: result registers
    rd_chk(2'b11, 6'd1, 2'd0, W'(3), '0, "R7 result 1");
    rd_chk(2'b11, 6'd2, 2'd0, W'(7), '0, "R7 result 2");
    rd_chk(2'b11, 6'd3, 2'd0, W'(3), '0, "R7 result 3");
    rd_chk(2'b11, 6'd0, 2'd0, W'(0), '0, "R7 result 0 after miss");
    // R9: select field has no effect on reads
    rd_chk(2'b00, 6'd7, 2'd0, KA, 72'hFF, "R9 read gsel 0");
    rd_chk(2'b00, 6'd7, 2'd3, KA, 72'hFF, "R9 read gsel 3");
    look_chk(KA ^ 72'h100, 2'd3, 2'd0, 0, 6'd0, 0, "R9 gsel on read wrote nothing");
    // random overlapping traffic, checked by the model (R1..R9)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk_i);
      req_i = ($urandom() % 2) == 0;
      begin
        int a;
        a = $urandom() % N;
        key_i = m_data[a];
        if ($urandom() % 2) key_i[$urandom() % W] ^= 1'b1;
      end
      gmask_sel_i = GW'($urandom());
      result_sel_i = RW'($urandom());
      mnt_valid_i = ($urandom() % 3) != 0;
      mnt_op_i = 2'($urandom());
      mnt_addr_i = AW'($urandom());
      mnt_gsel_i = GW'($urandom());
      mnt_data_i = (mnt_op_i == 2'b10) ? (rnd_w() & rnd_w() & rnd_w() & rnd_w()) : rnd_w();
      mnt_mask_i = rnd_w() & rnd_w() & rnd_w();
    end
    @(negedge clk_i);
    req_i = 0; mnt_valid_i = 0;
    repeat (4) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule